// File: doc/BRIEF.md
# Event Input Routing Multiplexer

This block delivers one event, picked from a vector of candidate sources, to a single target that runs on its own clock. The picked signal can be inverted first. An optional catch stage then holds a short source pulse, even one far narrower than the target clock period, until the target side has seen it. An optional two-flop synchronizer moves the event into the target clock domain. An optional edge stage reduces each event to a strobe one target cycle wide.

Each stage is switched by its own configuration input. A stage that is switched off is bypassed. With every stage off, the output is the selected and inverted source, passed through combinationally. An event that arrives while an earlier one is still waiting for acknowledgement merges into the same output strobe. To serve several targets, instantiate the block once for each target.

Top module: `evt_route_mux`

## Requirements
- R1: With catch, synchronizer and edge stages all disabled and invert off, `evt_o` equals `src_i[cfg_sel]` combinationally. Source index `i` is selected by `cfg_sel == i`.
- R2: With `cfg_inv` = 1 and all stages disabled, `evt_o` is the logical inverse of `src_i[cfg_sel]`.
- R3: With only the synchronizer enabled, a change on the selected source made between target edges k-1 and k appears on `evt_o` after edge k+1, and not after edge k. Rising and falling changes behave the same way.
- R4: With catch and synchronizer enabled, a selected-source pulse narrower than one target period, placed between edges k-1 and k, drives `evt_o` high after edges k+1 and k+2 and low again after edge k+3.
- R5: With catch, synchronizer and edge stages enabled, each caught event gives `evt_o` high for exactly one target cycle, after edge k+1.
- R6: With synchronizer and edge stages enabled and no catch, a selected source held high gives one single-cycle strobe, and `evt_o` then stays low while the source stays high.
- R7: A second or third short pulse that arrives after the first and before the catch stage is released (up to edge k+3) merges into the first. It gives no extra output strobe. A pulse that comes later produces a new strobe.
- R8: While `rst` is high, all stage flops are cleared and the catch stage cannot be set. After `rst` falls, with the synchronizer enabled, `evt_o` is low, even if the source pulsed during reset.
- R9: Activity on sources that are not selected has no effect on `evt_o`.
- R10: With `cfg_inv` = 1 and the catch stage enabled, the catch stage responds to a short low-going pulse on the selected source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target clock |
| rst | input | 1 | Synchronous active-high reset; also forces the catch stage clear |
| src_i | input | NUM_SRC | Candidate event sources, asynchronous to clk |
| cfg_sel | input | SEL_W | Index of the routed source |
| cfg_inv | input | 1 | Invert the selected source |
| cfg_cap_en | input | 1 | Enable the pulse-catch stage |
| cfg_sync_en | input | 1 | Enable the two-flop synchronizer |
| cfg_pulse_en | input | 1 | Enable single-cycle strobe generation |
| evt_o | output | 1 | Routed event in the target clock domain |

## Verification
Two functions can fall in the same cycle. One is the acknowledgement that releases the catch stage. The other is a fresh source edge that tries to set the catch stage again. The bench provokes this by placing extra narrow pulses just before the synchronized copy rises and while it is still high. It judges the result by counting output strobes over a fixed window: exactly one strobe must appear, and a later isolated pulse must still produce its own strobe. A second collision is reset against source activity. Here the bench pulses the selected source while `rst` is high and checks that no event appears after release.

// File: rtl/evt_route_pkg.sv
package evt_route_pkg;

    localparam int unsigned SYNC_DEPTH = 2;

    typedef struct packed {
        logic inv;
        logic cap_en;
        logic sync_en;
        logic pulse_en;
    } evt_mode_t;

    function automatic logic rise_of(input logic cur, input logic prev);
        return cur & ~prev;
    endfunction

endpackage

// File: rtl/evt_src_pick.sv
module evt_src_pick #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] src,
    input  logic [SEL_W-1:0]   sel,
    input  logic               inv,
    output logic               sig
);
    logic raw;

    always_comb begin
        raw = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel == SEL_W'(i)) raw = src[i];
        end
        sig = raw ^ inv;
    end
endmodule

// File: rtl/evt_catch.sv
module evt_catch (
    input  logic evt,
    input  logic clr,
    input  logic en,
    output logic held
);
    logic q;

    always_ff @(posedge evt or posedge clr) begin
        if (clr) q <= 1'b0;
        else     q <= 1'b1;
    end

    assign held = en ? q : evt;
endmodule

// File: rtl/evt_sync.sv
module evt_sync #(
    parameter int unsigned STAGES = evt_route_pkg::SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk
            // R3
            sync_rise_lag_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(dout) |-> $past(din, 2));
            // R3
            sync_fall_lag_chk: assert property (@(posedge clk) disable iff (rst)
                $fell(dout) |-> !$past(din, 2));
        end
    endgenerate
endmodule

// File: rtl/evt_strobe.sv
module evt_strobe
    import evt_route_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic v,
    output logic out
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= v;
    end

    assign out = en ? rise_of(v, prev) : v;

    // R5
    strobe_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (en && out) |=> (!en || !out));
endmodule

// File: rtl/evt_route_mux.sv
module evt_route_mux
    import evt_route_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic               cfg_inv,
    input  logic               cfg_cap_en,
    input  logic               cfg_sync_en,
    input  logic               cfg_pulse_en,
    output logic               evt_o
);
    evt_mode_t mode;
    logic      picked;
    logic      caught;
    logic      synced;
    logic      staged;
    logic      catch_clr;

    assign mode = '{inv: cfg_inv, cap_en: cfg_cap_en,
                    sync_en: cfg_sync_en, pulse_en: cfg_pulse_en};

    evt_src_pick #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_pick (
        .src (src_i),
        .sel (cfg_sel),
        .inv (mode.inv),
        .sig (picked)
    );

    // acknowledge from the target domain, reset, or stage switched off
    assign catch_clr = rst | synced | ~mode.cap_en;

    evt_catch u_catch (
        .evt  (picked),
        .clr  (catch_clr),
        .en   (mode.cap_en),
        .held (caught)
    );

    evt_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (caught),
        .dout (synced)
    );

    assign staged = mode.sync_en ? synced : caught;

    evt_strobe u_strobe (
        .clk (clk),
        .rst (rst),
        .en  (mode.pulse_en),
        .v   (staged),
        .out (evt_o)
    );

    // R8
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(rst) && cfg_sync_en) |-> !evt_o);
endmodule

// File: tb/evt_route_mux_tb.sv
module evt_route_mux_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 8;
    localparam int NVEC = 9;
    // {src[7:0], sel[2:0], inv, expected}
    localparam logic [12:0] VEC [NVEC] = '{
        {8'b1010_0101, 3'd0, 1'b0, 1'b1},
        {8'b1010_0101, 3'd1, 1'b0, 1'b0},
        {8'b1010_0101, 3'd7, 1'b0, 1'b1},
        {8'b1010_0101, 3'd6, 1'b0, 1'b0},
        {8'b0000_0001, 3'd0, 1'b1, 1'b0},
        {8'b0000_0001, 3'd3, 1'b1, 1'b1},
        {8'b1111_1111, 3'd4, 1'b0, 1'b1},
        {8'b1000_0000, 3'd7, 1'b1, 1'b0},
        {8'b0111_1111, 3'd7, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NSRC-1:0] src_i = '0;
    logic [2:0] cfg_sel = '0;
    logic cfg_inv = 1'b0, cfg_cap_en = 1'b0, cfg_sync_en = 1'b0, cfg_pulse_en = 1'b0;
    logic evt_o;
    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_route_mux #(.NUM_SRC(NSRC)) u_dut (
        .clk(clk), .rst(rst), .src_i(src_i), .cfg_sel(cfg_sel), .cfg_inv(cfg_inv),
        .cfg_cap_en(cfg_cap_en), .cfg_sync_en(cfg_sync_en), .cfg_pulse_en(cfg_pulse_en),
        .evt_o(evt_o)
    );

    task automatic check(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: evt_o=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_int(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: count=%0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic narrow(input int idx);
        src_i[idx] = ~src_i[idx];
        #1;
        src_i[idx] = ~src_i[idx];
    endtask

    task automatic quiesce();
        cfg_cap_en = 1'b0; cfg_pulse_en = 1'b0; cfg_sync_en = 1'b0; cfg_inv = 1'b0;
        src_i = '0;
        repeat (5) tick();
    endtask

    task automatic count_hi(input int cycles, output int cnt);
        cnt = 0;
        for (int c = 0; c < cycles; c++) begin
            tick();
            if (evt_o) cnt++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int cnt;
        // R8: reset state with the synchronizer on and the source pulsed during reset
        cfg_sync_en = 1'b1; cfg_cap_en = 1'b1; cfg_sel = 3'd2;
        repeat (3) tick();
        narrow(2);
        tick();
        rst = 1'b0;
        check(evt_o, 1'b0, "R8 first cycle after reset");
        count_hi(5, cnt);
        check_int(cnt, 0, "R8 no event from pulse in reset");
        quiesce();

        // R1/R2 table walk, all stages bypassed
        for (int i = 0; i < NVEC; i++) begin
            src_i = VEC[i][12:5];
            cfg_sel = VEC[i][4:2];
            cfg_inv = VEC[i][1];
            #1;
            check(evt_o, VEC[i][0], VEC[i][1] ? "R2 inverted bypass" : "R1 selected bypass");
        end
        quiesce();

        // R3 synchronizer latency, rise then fall
        cfg_sync_en = 1'b1; cfg_sel = 3'd3;
        tick();
        src_i[3] = 1'b1;
        tick(); check(evt_o, 1'b0, "R3 rise not after edge k");
        tick(); check(evt_o, 1'b1, "R3 rise after edge k+1");
        src_i[3] = 1'b0;
        tick(); check(evt_o, 1'b1, "R3 fall not after edge k");
        tick(); check(evt_o, 1'b0, "R3 fall after edge k+1");
        quiesce();

        // R4 narrow pulse caught and synchronized
        cfg_sync_en = 1'b1; cfg_sel = 3'd1;
        tick(); cfg_cap_en = 1'b1;
        tick();
        narrow(1);
        tick(); check(evt_o, 1'b0, "R4 after edge k");
        tick(); check(evt_o, 1'b1, "R4 after edge k+1");
        tick(); check(evt_o, 1'b1, "R4 after edge k+2");
        tick(); check(evt_o, 1'b0, "R4 after edge k+3");
        quiesce();

        // R5 narrow pulse to single-cycle strobe
        cfg_sync_en = 1'b1; cfg_sel = 3'd6;
        tick(); cfg_cap_en = 1'b1; cfg_pulse_en = 1'b1;
        tick();
        narrow(6);
        tick(); check(evt_o, 1'b0, "R5 after edge k");
        tick(); check(evt_o, 1'b1, "R5 strobe after edge k+1");
        tick(); check(evt_o, 1'b0, "R5 strobe ends after edge k+2");
        count_hi(4, cnt);
        check_int(cnt, 0, "R5 no repeat strobe");
        quiesce();

        // R6 held level gives one strobe
        cfg_sync_en = 1'b1; cfg_pulse_en = 1'b1; cfg_sel = 3'd0;
        tick();
        src_i[0] = 1'b1;
        tick(); tick(); check(evt_o, 1'b1, "R6 strobe on level");
        count_hi(6, cnt);
        check_int(cnt, 0, "R6 low while level held");
        quiesce();

        // R7 merge of events before acknowledgement
        cfg_sync_en = 1'b1; cfg_sel = 3'd4;
        tick(); cfg_cap_en = 1'b1; cfg_pulse_en = 1'b1;
        tick();
        narrow(4);
        cnt = 0;
        tick(); if (evt_o) cnt++;
        narrow(4);
        tick(); if (evt_o) cnt++;
        narrow(4);
        tick(); if (evt_o) cnt++;
        narrow(4);
        for (int c = 0; c < 6; c++) begin tick(); if (evt_o) cnt++; end
        check_int(cnt, 1, "R7 merged into one strobe");
        narrow(4);
        count_hi(6, cnt);
        check_int(cnt, 1, "R7 later pulse gives new strobe");
        quiesce();

        // R9 unselected sources ignored
        cfg_sync_en = 1'b1; cfg_sel = 3'd2;
        tick(); cfg_cap_en = 1'b1;
        tick();
        src_i = 8'b1111_1011;
        narrow(5); narrow(7);
        count_hi(5, cnt);
        check_int(cnt, 0, "R9 other sources ignored");
        src_i = 8'b0000_0000;
        count_hi(3, cnt);
        check_int(cnt, 0, "R9 other sources ignored on release");
        quiesce();

        // R10 inverted catch on a low-going pulse
        src_i[5] = 1'b1; cfg_sel = 3'd5; cfg_inv = 1'b1;
        cfg_sync_en = 1'b1; cfg_pulse_en = 1'b1;
        repeat (4) tick();
        cfg_cap_en = 1'b1;
        repeat (2) tick();
        check(evt_o, 1'b0, "R10 idle before pulse");
        narrow(5);
        count_hi(6, cnt);
        check_int(cnt, 1, "R10 low pulse caught");
        quiesce();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule